// File: doc/BRIEF.md
# Packed Unsigned Widening Unit

This execution unit takes a 128-bit packed source and a conversion opcode. It returns a 256-bit destination value in which the unsigned elements from the low end of the source are widened into larger lanes. Every new bit in each lane is zero. There are six widening ratios: byte to word, byte to dword, byte to qword, word to dword, word to qword and dword to qword. A 2-bit encoding mode controls the upper 128 bits of the destination. In the merged 128-bit mode they keep the old register contents. In the cleared 128-bit mode they are zeroed. In the wide mode they are computed from a source window twice as large.

The surrounding pipeline supplies three inputs with each operation: the source, the old upper half of the destination register, and a 4-bit spare register field. In the two cleared and wide modes the spare field must read all ones. Any other value is an illegal encoding. An illegal encoding raises a fault and suppresses the register write. The unit is one registered stage and accepts one operation per cycle.

Top module: `zext_widen_unit`

## Requirements
- R1: After synchronous active-high reset, `out_valid`, `out_wr_en` and `out_fault` are all 0.
- R2: The opcode selects the ratio as follows: 0x30 byte→word, 0x31 byte→dword, 0x32 byte→qword, 0x33 word→dword, 0x34 word→qword, 0x35 dword→qword.
- R3: Source element i, counted from bit 0 upward, is zero-extended into destination lane i. An all-ones source yields lanes whose bits above the source element width are zero.
- R4: In mode 2'b00 (merged 128-bit), result bits 255:128 equal `in_keep_hi`, and bits 127:0 hold the widened elements.
- R5: In mode 2'b01 (cleared 128-bit), result bits 255:128 are zero.
- R6: In mode 2'b10 (wide), the source window covers 16, 8 or 4 bytes. The next group of consecutive source elements fills bits 255:128, continuing the element order of bits 127:0.
- R7: In modes 2'b01 and 2'b10, a spare field `in_spare` other than 4'b1111 raises `out_fault`. In mode 2'b00 the spare field is ignored.
- R8: Any of the following raises `out_fault`: an opcode outside 0x30–0x35, mode 2'b11, or the spare-field violation in R7. When `out_fault` is high, `out_wr_en` is 0 and `out_result` is zero.
- R9: Outputs appear exactly one clock after `in_valid`. `out_valid` is low after an idle input cycle, and `out_wr_en` is high only for a valid, fault-free operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_opcode | input | 8 | Conversion opcode, 0x30–0x35 |
| in_mode | input | 2 | 00 merged 128, 01 cleared 128, 10 wide 256 |
| in_spare | input | 4 | Spare register field, must be 4'b1111 in modes 01/10 |
| in_src | input | 128 | Packed source operand |
| in_keep_hi | input | 128 | Old destination bits 255:128 |
| out_valid | output | 1 | Result present |
| out_result | output | 256 | Destination value |
| out_wr_en | output | 1 | Register write enable |
| out_fault | output | 1 | Invalid-opcode fault |

## Verification
The assertions check the following on every cycle. The one-cycle valid latency holds. A fault never comes with a write. Bad opcodes, bad modes and bad spare fields always fault. The upper half is merged from `in_keep_hi` or cleared according to the mode. The lane-by-lane widening for each ratio and each window position can only be shown by the bench scenarios. They compare every opcode and mode pairing against an element-wise reference model, using random sources and an all-ones source that would expose sign leakage.

// File: rtl/zext_widen_unit.sv
module zext_widen_unit #(
  parameter int SRC_W = 128,
  parameter int DST_W = 256,
  parameter logic [7:0] OP_BASE = 8'h30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_opcode,
  input  logic [1:0]       in_mode,
  input  logic [3:0]       in_spare,
  input  logic [SRC_W-1:0] in_src,
  input  logic [SRC_W-1:0] in_keep_hi,
  output logic             out_valid,
  output logic [DST_W-1:0] out_result,
  output logic             out_wr_en,
  output logic             out_fault
);
  localparam int HALF_W     = DST_W / 2;
  localparam int HALF_BYTES = HALF_W / 8;
  localparam logic [1:0] MODE_MERGE = 2'd0;
  localparam logic [1:0] MODE_CLEAR = 2'd1;
  localparam logic [1:0] MODE_WIDE  = 2'd2;

  function automatic logic [HALF_W-1:0] widen_half(input logic [SRC_W-1:0] win,
                                                   input int in_lg, input int out_lg);
    logic [HALF_W-1:0] r;
    r = '0;
    for (int k = 0; k < HALF_BYTES; k++) begin
      int lane, pos, sel;
      lane = k >> out_lg;
      pos  = k & ((1 << out_lg) - 1);
      sel  = lane * (1 << in_lg) + pos;
      if (pos < (1 << in_lg)) r[8*k +: 8] = win[8*sel +: 8];
    end
    return r;
  endfunction

  logic             op_ok, fault_c;
  int               in_lg, out_lg, shamt;
  logic [SRC_W-1:0] hi_win;
  logic [DST_W-1:0] result_c;

  always_comb begin
    op_ok  = 1'b1;
    in_lg  = 0;
    out_lg = 1;
    case (in_opcode)
      OP_BASE:        begin in_lg = 0; out_lg = 1; end
      OP_BASE + 8'd1: begin in_lg = 0; out_lg = 2; end
      OP_BASE + 8'd2: begin in_lg = 0; out_lg = 3; end
      OP_BASE + 8'd3: begin in_lg = 1; out_lg = 2; end
      OP_BASE + 8'd4: begin in_lg = 1; out_lg = 3; end
      OP_BASE + 8'd5: begin in_lg = 2; out_lg = 3; end
      default:        op_ok = 1'b0;
    endcase
  end

  assign fault_c = !op_ok || (in_mode == 2'd3) ||
                   ((in_mode != MODE_MERGE) && (in_spare != 4'hF));

  always_comb begin
    shamt  = (HALF_BYTES >> (out_lg - in_lg)) * 8;
    hi_win = in_src >> shamt;
    result_c[HALF_W-1:0] = widen_half(in_src, in_lg, out_lg);
    case (in_mode)
      MODE_MERGE: result_c[DST_W-1:HALF_W] = in_keep_hi;
      MODE_WIDE:  result_c[DST_W-1:HALF_W] = widen_half(hi_win, in_lg, out_lg);
      default:    result_c[DST_W-1:HALF_W] = '0;
    endcase
    if (fault_c) result_c = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_fault  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= in_valid && !fault_c;
      out_fault <= in_valid && fault_c;
      if (in_valid) out_result <= result_c;
    end
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_wr_en);
  a_r8_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> !out_wr_en && out_valid);
  a_r8_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_opcode < OP_BASE || in_opcode > OP_BASE + 8'd5) |=> out_fault);
  a_r8_bad_mode: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode == 2'd3 |=> out_fault);
  a_r7_spare_check: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode != MODE_MERGE && in_spare != 4'hF |=> out_fault);
  a_r4_merge_upper: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode == MODE_MERGE && in_opcode >= OP_BASE && in_opcode <= OP_BASE + 8'd5
    |=> out_wr_en && out_result[DST_W-1:HALF_W] == $past(in_keep_hi));
  a_r5_clear_upper: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode == MODE_CLEAR |=> out_result[DST_W-1:HALF_W] == '0);
endmodule

// File: tb/zext_widen_unit_tb.sv
module zext_widen_unit_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [7:0]   in_opcode;
  logic [1:0]   in_mode;
  logic [3:0]   in_spare;
  logic [127:0] in_src;
  logic [127:0] in_keep_hi;
  logic         out_valid;
  logic [255:0] out_result;
  logic         out_wr_en;
  logic         out_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  zext_widen_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_mode(in_mode), .in_spare(in_spare), .in_src(in_src),
    .in_keep_hi(in_keep_hi), .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_fault(out_fault)
  );

  function automatic bit exp_fault(input logic [7:0] op, input logic [1:0] md,
                                   input logic [3:0] sp);
    return (op < 8'h30) || (op > 8'h35) || (md == 2'd3) || (md != 2'd0 && sp != 4'hF);
  endfunction

  function automatic logic [255:0] ref_model(input logic [7:0] op, input logic [1:0] md,
                                             input logic [127:0] src, input logic [127:0] keep);
    logic [255:0] d;
    int iw, ow, n;
    d = '0;
    case (op)
      8'h30: begin iw = 8;  ow = 16; end
      8'h31: begin iw = 8;  ow = 32; end
      8'h32: begin iw = 8;  ow = 64; end
      8'h33: begin iw = 16; ow = 32; end
      8'h34: begin iw = 16; ow = 64; end
      default: begin iw = 32; ow = 64; end
    endcase
    n = ((md == 2'd2) ? 256 : 128) / ow;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < iw; b++)
        d[i*ow + b] = src[i*iw + b];
    if (md == 2'd0) d[255:128] = keep;
    return d;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [1:0] md, input logic [3:0] sp,
                        input logic [127:0] src, input logic [127:0] keep);
    bit f;
    string req;
    f = exp_fault(op, md, sp);
    in_valid = 1'b1; in_opcode = op; in_mode = md; in_spare = sp;
    in_src = src; in_keep_hi = keep;
    @(negedge clk);
    in_valid = 1'b0;
    if (f) req = (op >= 8'h30 && op <= 8'h35 && md != 2'd3) ? "R7" : "R8";
    else if (md == 2'd0) req = "R4";
    else if (md == 2'd1) req = "R5";
    else req = "R6";
    check_bit("R9 valid", out_valid, 1'b1);
    check_bit({req, " fault"}, out_fault, f);
    check_bit({req, " write"}, out_wr_en, !f);
    check_vec({req, " R2 R3 result"}, out_result, f ? 256'h0 : ref_model(op, md, src, keep));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] r;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; in_opcode = 8'h30; in_mode = 2'd0;
    in_spare = 4'hF; in_src = '0; in_keep_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R1 valid", out_valid, 1'b0);
    check_bit("R1 write", out_wr_en, 1'b0);
    check_bit("R1 fault", out_fault, 1'b0);

    // R3: all-ones source across every ratio and mode
    for (int o = 0; o < 6; o++)
      for (int m = 0; m < 3; m++)
        run_op(8'h30 + 8'(o), 2'(m), 4'hF, {128{1'b1}}, {4{32'hA5A5_5A5A}});

    // R6: distinct bytes to expose window placement
    for (int o = 0; o < 6; o++) begin
      for (int k = 0; k < 16; k++) r[8*k +: 8] = 8'(8'h80 + k);
      run_op(8'h30 + 8'(o), 2'd2, 4'hF, r, '1);
    end

    // R7: spare field ignored in merged mode, faults elsewhere
    run_op(8'h33, 2'd0, 4'h0, {4{$urandom}}, {4{$urandom}});
    run_op(8'h33, 2'd1, 4'hE, {4{$urandom}}, {4{$urandom}});
    run_op(8'h35, 2'd2, 4'h7, {4{$urandom}}, {4{$urandom}});

    // R8: bad opcodes and bad mode
    run_op(8'h2F, 2'd0, 4'hF, {4{$urandom}}, {4{$urandom}});
    run_op(8'h36, 2'd2, 4'hF, {4{$urandom}}, {4{$urandom}});
    run_op(8'h31, 2'd3, 4'hF, {4{$urandom}}, {4{$urandom}});

    // R9: idle cycle drops valid and write
    @(negedge clk);
    check_bit("R9 idle valid", out_valid, 1'b0);
    check_bit("R9 idle write", out_wr_en, 1'b0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [1:0] md;
      logic [3:0] sp;
      op = 8'h30 + 8'($urandom_range(0, 5));
      if ($urandom_range(0, 15) == 0) op = 8'($urandom);
      md = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 15) == 0) md = 2'd3;
      sp = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      run_op(op, md, sp, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule